// File: doc/BRIEF.md
# Pipelined Linked-List Summing Engine

The engine walks a singly linked list that sits in an external memory and accumulates the signed values held in its nodes. Pointers and values share one width (8 bits by default), so a node is two consecutive words: the pointer to the following node at the node's own address `p`, and the two's complement value at `p+1`. The list always begins at address 0, and a pointer of 0 ends it. The memory is read combinationally through one address/data port pair.

A one-cycle pulse on `start` clears the running total and begins the walk. The loop is software-pipelined over two alternating phases. A value phase fetches a node value into a holding register and forms the next value address by incrementing the current pointer. A pointer phase fetches the following pointer and adds the held value into the total. Each cycle therefore has at most one memory read and one addition, and the two never depend on each other within that cycle. A single adder is shared between the two phases. A prologue cycle loads the head pointer. Once the pointer register reads zero, one more value phase and one drain cycle add the last value, and then `done` rises.

Top module: `llsum_engine`

## Requirements
- R1: While and after synchronous reset, with no start seen, `done` is low and `result` is 0.
- R2: In the cycle after `start` is sampled high, the engine drives `mem_addr` = 0 to fetch the head pointer.
- R3: After the head fetch, value phases and pointer phases alternate. For a list whose node addresses are p0=0, p1, …, p(N-1), with pN taken as 0, the address in the k-th cycle after the start edge (k counted from 0) is p(k/2) for even k and p((k-1)/2)+1 for odd k, up to k = 2N.
- R4: `result` is the sum of all node values modulo 2^8. Values and the sum are two's complement, and overflow wraps silently.
- R5: A list whose head pointer (address 0) is 0 has one node, and its result is the value at address 1.
- R6: For a list of N nodes, `done` first reads high exactly 2N+1 clock edges after the edge that sampled `start`.
- R7: Once `done` is high it stays high, and `result` stays unchanged, until the next `start`.
- R8: A `start` sampled during a walk abandons it. The following cycle fetches address 0 with the total cleared, and the result covers only the list present after the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin (or restart) a walk from address 0 |
| done | output | 1 | Result is final |
| result | output | 8 | Accumulated sum, two's complement |
| mem_addr | output | 8 | Memory read address |
| mem_rdata | input | 8 | Memory read data (combinational) |

## Verification
Two things can fall in the same cycle. The pointer phase reads the next pointer while the shared adder accumulates the value fetched one cycle earlier. The value phase reads a value while the same adder forms the next value address. The bench places nodes at shuffled addresses with random, negative and overflow-prone values, so a mis-steered adder operand or a wrong address choice shows up both in the sum and in the per-cycle address trace. These are compared against a reference walk and total computed in the bench. A second overlap, a restart arriving mid-walk, is provoked by pulsing `start` during a long list and rewriting the memory, and it is judged by requiring the latency and sum of the new list alone.

// File: rtl/llsum_pkg.sv
package llsum_pkg;

    localparam int unsigned LL_WORD_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HEAD,
        PH_VALUE,
        PH_POINTER,
        PH_DRAIN,
        PH_FINISHED
    } phase_e;

    typedef struct packed {
        logic clear;       // initialise all datapath registers
        logic load_ptr;    // pointer register takes memory data
        logic load_hold;   // holding register takes memory data
        logic load_vaddr;  // value-address register takes adder output
        logic load_acc;    // accumulator takes adder output
        logic addr_vaddr;  // 1: address from value-address reg, 0: from pointer reg
        logic add_acc;     // 1: adder computes acc+hold, 0: pointer+1
    } ctl_t;

    function automatic ctl_t phase_controls(input phase_e ph, input logic restart);
        ctl_t c;
        c = '0;
        c.clear = restart;
        unique case (ph)
            PH_HEAD: begin
                c.load_ptr = 1'b1;
            end
            PH_VALUE: begin
                c.load_hold  = 1'b1;
                c.load_vaddr = 1'b1;
                c.addr_vaddr = 1'b1;
            end
            PH_POINTER: begin
                c.load_ptr = 1'b1;
                c.load_acc = 1'b1;
                c.add_acc  = 1'b1;
            end
            PH_DRAIN: begin
                c.load_acc = 1'b1;
                c.add_acc  = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/llsum_ctrl.sv
module llsum_ctrl
    import llsum_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   ptr_is_zero,
    output phase_e phase,
    output ctl_t   ctl,
    output logic   finished
);

    phase_e phase_q, phase_d;

    always_comb begin
        phase_d = phase_q;
        if (start) begin
            phase_d = PH_HEAD;
        end else begin
            unique case (phase_q)
                PH_HEAD:    phase_d = PH_VALUE;
                PH_VALUE:   phase_d = ptr_is_zero ? PH_DRAIN : PH_POINTER;
                PH_POINTER: phase_d = PH_VALUE;
                PH_DRAIN:   phase_d = PH_FINISHED;
                default:    phase_d = phase_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end

    always_comb ctl = phase_controls(phase_q, start);

    assign phase    = phase_q;
    assign finished = (phase_q == PH_FINISHED);

    AST_VALUE_THEN_POINTER: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_VALUE && !start) |=> (phase_q == PH_POINTER || phase_q == PH_DRAIN)); // R3

    AST_FINISH_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst)
        $rose(finished) |-> ($past(phase_q) == PH_DRAIN)); // R6

endmodule

// File: rtl/llsum_adder.sv
module llsum_adder #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] total
);
    assign total = op_a + op_b;
endmodule

// File: rtl/llsum_dp.sv
module llsum_dp
    import llsum_pkg::*;
#(
    parameter int unsigned W = LL_WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  ctl_t         ctl,
    input  logic [W-1:0] mem_rdata,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] acc,
    output logic         ptr_is_zero
);

    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] ptr_q, vaddr_q, hold_q, acc_q;
    logic [W-1:0] add_a, add_b, add_y;

    // shared adder: pointer+1 in the value phase, acc+hold otherwise
    assign add_a = ctl.add_acc ? acc_q  : ptr_q;
    assign add_b = ctl.add_acc ? hold_q : ONE;

    llsum_adder #(.W(W)) u_adder (
        .op_a  (add_a),
        .op_b  (add_b),
        .total (add_y)
    );

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            ptr_q   <= ZERO;
            vaddr_q <= ONE;
            hold_q  <= ZERO;
            acc_q   <= ZERO;
        end else begin
            if (ctl.load_ptr)   ptr_q   <= mem_rdata;
            if (ctl.load_hold)  hold_q  <= mem_rdata;
            if (ctl.load_vaddr) vaddr_q <= add_y;
            if (ctl.load_acc)   acc_q   <= add_y;
        end
    end

    assign mem_addr    = ctl.addr_vaddr ? vaddr_q : ptr_q;
    assign acc         = acc_q;
    assign ptr_is_zero = (ptr_q == ZERO);

    AST_VADDR_TRACKS_PTR: assert property (@(posedge clk) disable iff (rst)
        ($past(ctl.load_vaddr) && !$past(ctl.clear)) |-> (vaddr_q == $past(ptr_q) + ONE)); // R3

    AST_CLEAR_ZEROES_ACC: assert property (@(posedge clk) disable iff (rst)
        ctl.clear |=> (acc_q == ZERO)); // R8

endmodule

// File: rtl/llsum_engine.sv
module llsum_engine
    import llsum_pkg::*;
#(
    parameter int unsigned W = LL_WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    output logic         done,
    output logic [W-1:0] result,
    output logic [W-1:0] mem_addr,
    input  logic [W-1:0] mem_rdata
);

    phase_e phase;
    ctl_t   ctl;
    logic   ptr_is_zero;

    llsum_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .ptr_is_zero (ptr_is_zero),
        .phase       (phase),
        .ctl         (ctl),
        .finished    (done)
    );

    llsum_dp #(.W(W)) u_dp (
        .clk         (clk),
        .rst         (rst),
        .ctl         (ctl),
        .mem_rdata   (mem_rdata),
        .mem_addr    (mem_addr),
        .acc         (result),
        .ptr_is_zero (ptr_is_zero)
    );

    AST_HEAD_FETCH_ZERO: assert property (@(posedge clk) disable iff (rst)
        start |=> (mem_addr == '0)); // R2

    AST_RESTART_DROPS_DONE: assert property (@(posedge clk) disable iff (rst)
        start |=> !done); // R8

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(result))); // R7

endmodule

// File: tb/llsum_engine_tb_top.sv
`timescale 1ns/1ps
module llsum_engine_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       done;
    logic [7:0] result, mem_addr, mem_rdata;

    logic [7:0] mem [256];
    int         nodes [0:128];
    logic [7:0] vals [0:127];
    logic [7:0] exp_sum;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         finished_run = 1'b0;

    always #2 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    llsum_engine dut_i (
        .clk(clk), .rst(rst), .start(start), .done(done),
        .result(result), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic build_list(input int n);
        int pool [0:126];
        int j, t;
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
        for (int i = 0; i < 127; i++) pool[i] = 2 + 2 * i;
        for (int i = 126; i > 0; i--) begin
            j = int'($urandom % (i + 1));
            t = pool[i]; pool[i] = pool[j]; pool[j] = t;
        end
        nodes[0] = 0;
        for (int k = 1; k < n; k++) nodes[k] = pool[k - 1];
        nodes[n] = 0;
        exp_sum = 8'd0;
        for (int k = 0; k < n; k++) begin
            mem[nodes[k]]     = 8'(nodes[k + 1]);
            mem[nodes[k] + 1] = vals[k];
            exp_sum = exp_sum + vals[k];
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // called right after pulse_start: now k = 0 (head fetch)
    task automatic wait_done(input int n, input string tag);
        int  k = 0;
        int  bad_k = -1;
        int  exp_a, act_a;
        bit  hung = 1'b0;
        check(mem_addr == 8'd0, {"R2 head address ", tag}, mem_addr, 0);
        while (!done) begin
            if (k % 2 == 0) exp_a = nodes[k / 2];
            else            exp_a = nodes[(k - 1) / 2] + 1;
            if (k <= 2 * n && bad_k < 0 && int'(mem_addr) != exp_a) begin
                bad_k = k; act_a = mem_addr;
            end
            @(negedge clk);
            k++;
            if (k > 600) begin hung = 1'b1; break; end
        end
        check(bad_k < 0, {"R3 address trace ", tag}, bad_k < 0 ? 0 : act_a, bad_k < 0 ? 0 : exp_a);
        check(!hung && k == 2 * n + 1, {"R6 latency ", tag}, k, 2 * n + 1);
        check(result == exp_sum, {"R4 sum ", tag}, result, exp_sum);
    endtask

    task automatic check_hold(input string tag);
        logic [7:0] r0;
        r0 = result;
        repeat (3) @(negedge clk);
        check(done && result == r0, {"R7 hold ", tag}, result, r0);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished_run) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem[i] = 8'd0;
        repeat (3) @(negedge clk);
        check(done == 1'b0 && result == 8'd0, "R1 reset state", done, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(done == 1'b0 && result == 8'd0, "R1 idle after reset", done, 0);

        // R5: single node, head pointer 0
        vals[0] = 8'hF6;
        build_list(1);
        pulse_start();
        wait_done(1, "single");
        check(result == 8'hF6, "R5 single node value", result, 8'hF6);
        check_hold("single");

        // R4: positive overflow wraps: 3 x 100 = 300 -> 44
        for (int k = 0; k < 3; k++) vals[k] = 8'd100;
        build_list(3);
        pulse_start();
        wait_done(3, "wrap-pos");
        check(result == 8'd44, "R4 positive wrap", result, 44);

        // R4: negative overflow: -128 + -1 -> 127
        vals[0] = 8'h80; vals[1] = 8'hFF;
        build_list(2);
        pulse_start();
        wait_done(2, "wrap-neg");
        check(result == 8'h7F, "R4 negative wrap", result, 127);

        // long chain
        for (int k = 0; k < 120; k++) vals[k] = 8'($urandom);
        build_list(120);
        pulse_start();
        wait_done(120, "long");
        check_hold("long");

        // R8: abort a running walk and restart on a new list
        for (int k = 0; k < 40; k++) vals[k] = 8'($urandom);
        build_list(40);
        pulse_start();
        repeat (10) @(negedge clk);
        check(done == 1'b0, "R8 busy mid-walk", done, 0);
        for (int k = 0; k < 5; k++) vals[k] = 8'($urandom);
        build_list(5);
        pulse_start();
        wait_done(5, "restart");

        // R8: restart from the finished state
        for (int k = 0; k < 7; k++) vals[k] = 8'($urandom);
        build_list(7);
        pulse_start();
        wait_done(7, "after-done");

        // random lists
        for (int it = 0; it < 25; it++) begin
            n = 1 + int'($urandom % 64);
            for (int k = 0; k < n; k++) vals[k] = 8'($urandom);
            build_list(n);
            pulse_start();
            wait_done(n, "random");
        end

        finished_run = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule